// File: doc/BRIEF.md
# Serial Port Register and Interrupt Front End

This block is the software-facing side of a byte-oriented serial controller. Software reaches it through a simple one-cycle register bus. It can read and write a mode word, a bit-rate value, a control word and a FIFO control word. It can push bytes out through a transmit data register and pull received bytes in through a receive data register. It can read a status word holding three event flags, and it can read a count of the bytes waiting on the receive side. Toward the serial engine the block offers two byte handshakes. The transmit handshake presents a valid byte that is held until the engine accepts it. The receive handshake shows the byte the engine offers, and the block pops it when software reads it.

Three event flags live in the status word. The data-ready flag follows the receive side and is sampled on a periodic tick strobe. The transmit-empty and transmit-done flags are raised a programmable number of ticks after each transmit write. Software clears the flags by writing ones to the status word. Two level interrupt lines, one for receive and one for transmit, are formed from these flags and from two enable bits in the control word. Each line follows its inputs at all times, so any control or status write takes effect on the line in the cycle after the write.

The external reset is asynchronous and active low. Its release is synchronised inside the block, which takes two clock edges.

Top module: `uart_reg_front`

## Requirements
- R1: While reset is active, and after it is released, the mode, bit rate, control and FIFO control registers read as zero. All three status flags are zero, both interrupt lines are low and no transmit byte is offered.
- R2: Register address 0 (mode, 16 bits) and address 6 (FIFO control, 16 bits) store and return any written value. Address 1 (bit rate) keeps only the low 8 bits written and reads back with its upper bits zero.
- R3: The receive interrupt line is high exactly when control bit 0 (receive enable) is set and status bit 0 (data ready) is set.
- R4: The transmit interrupt line is high exactly when control bit 1 (transmit enable) is set and at least one of status bit 1 (transmit empty) or status bit 2 (transmit done) is set.
- R5: Address 4 reads the status word: bit 0 data ready, bit 1 transmit empty, bit 2 transmit done, other bits zero. A write to address 4 clears each flag whose data bit is 1 and leaves the others as they were. An event that sets a flag in the same cycle takes precedence over the clear.
- R6: A write to address 3 offers the low byte of the data on the transmit handshake from the next cycle. The byte stays offered and unchanged until a cycle in which the transmitter accepts it, unless another write to address 3 replaces it.
- R7: Each write to address 3 arms a countdown of TX_DELAY_TICKS ticks. A tick in the same cycle as the write does not count. On the tick that ends the countdown, the transmit-empty and transmit-done flags are both set.
- R8: A read of address 5 pops the receive handshake in that cycle. It returns the offered byte, or zero when none is offered. It clears data ready, and this clear takes precedence over a tick in the same cycle.
- R9: On each tick in which the receiver offers a byte, data ready is set.
- R10: A read of address 7 returns 1 when the receiver offers a byte and 0 otherwise.
- R11: Read data appears with a valid strobe exactly one cycle after the read. Address 3 reads as zero, and writes to addresses 5 and 7 have no effect.
- R12: Address 2 (control, 16 bits) stores and returns any written value. Writing an enable bit to zero drops its interrupt line in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe, one cycle after the read |
| tick | input | 1 | One-cycle periodic update strobe |
| rx_valid | input | 1 | Receiver offers a byte |
| rx_data | input | BYTE_W | Offered receive byte |
| rx_ready | output | 1 | Pop strobe to the receiver |
| tx_valid | output | 1 | Transmit byte offered |
| tx_data | output | BYTE_W | Offered transmit byte |
| tx_ready | input | 1 | Transmitter accepts the offered byte |
| irq_rx | output | 1 | Receive interrupt level |
| irq_tx | output | 1 | Transmit interrupt level |

## Verification
The bench builds the block with TX_DELAY_TICKS set to 2 and with the default 16-bit data and 8-bit byte widths. A countdown of two ticks exposes the intermediate state, in which one tick has passed and neither transmit flag is up yet. It also lets the random traffic place rewrites of the transmit register in the middle of a running countdown, and place ticks in the same cycle as the arming write. The 16-bit words show that the 8-bit bit-rate field drops its upper bits while the other stored registers keep them.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;

  typedef enum logic [2:0] {
    REG_MODE  = 3'd0,
    REG_RATE  = 3'd1,
    REG_CTRL  = 3'd2,
    REG_TXD   = 3'd3,
    REG_STAT  = 3'd4,
    REG_RXD   = 3'd5,
    REG_FCTL  = 3'd6,
    REG_RXCNT = 3'd7
  } reg_addr_e;

  localparam int CTRL_RIE = 0;
  localparam int CTRL_TIE = 1;

  // packed so that bit 0 is data ready, bit 1 tx empty, bit 2 tx done
  typedef struct packed {
    logic tend;
    logic te;
    logic dr;
  } flags_t;

  localparam int FLAG_W = $bits(flags_t);

endpackage

// File: rtl/uart_fe_rstsync.sv
module uart_fe_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/uart_fe_cfg.sv
module uart_fe_cfg
  import uart_fe_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_addr_e         wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] mode_q,
  output logic [RATE_W-1:0] rate_q,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] fctl_q
);
  logic mode_en, rate_en, ctrl_en, fctl_en;

  // R2 R12: plain storage with explicit enables
  always_comb begin
    mode_en = wr_en && (wr_addr == REG_MODE);
    rate_en = wr_en && (wr_addr == REG_RATE);
    ctrl_en = wr_en && (wr_addr == REG_CTRL);
    fctl_en = wr_en && (wr_addr == REG_FCTL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      rate_q <= '0;
      ctrl_q <= '0;
      fctl_q <= '0;
    end else begin
      if (mode_en) mode_q <= wr_data;
      if (rate_en) rate_q <= wr_data[RATE_W-1:0];
      if (ctrl_en) ctrl_q <= wr_data;
      if (fctl_en) fctl_q <= wr_data;
    end
  end
endmodule

// File: rtl/uart_fe_flags.sv
module uart_fe_flags
  import uart_fe_pkg::*;
#(
  parameter int BYTE_W         = 8,
  parameter int TX_DELAY_TICKS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx_valid,
  input  logic              rd_rx,
  input  logic              st_wr,
  input  logic [FLAG_W-1:0] st_clr,
  input  logic              tx_wr,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_ready,
  output flags_t            flags_q,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data
);
  localparam int CNT_W = $clog2(TX_DELAY_TICKS + 1);
  localparam logic [CNT_W-1:0] DLY = CNT_W'(TX_DELAY_TICKS);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  flags_t           flags_d;
  logic             fire;
  logic             txv_d;
  logic             txd_en;
  logic [FLAG_W-1:0] clr;

  always_comb begin
    clr  = st_wr ? st_clr : '0;
    // R7: countdown ends on the tick that sees a count of one
    fire = tick && (cnt_q == CNT_W'(1));

    if (tx_wr)                     cnt_d = DLY;
    else if (tick && cnt_q != '0)  cnt_d = cnt_q - CNT_W'(1);
    else                           cnt_d = cnt_q;

    // R8 R9 R5: read clear beats tick set, set beats a status clear
    if (rd_rx)                 flags_d.dr = 1'b0;
    else if (tick && rx_valid) flags_d.dr = 1'b1;
    else                       flags_d.dr = flags_q.dr & ~clr[0];

    flags_d.te   = fire | (flags_q.te   & ~clr[1]);
    flags_d.tend = fire | (flags_q.tend & ~clr[2]);

    // R6: offer held until accepted, a new write replaces it
    txd_en = tx_wr;
    if (tx_wr)                    txv_d = 1'b1;
    else if (tx_valid && tx_ready) txv_d = 1'b0;
    else                          txv_d = tx_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      flags_q  <= '0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      cnt_q    <= cnt_d;
      flags_q  <= flags_d;
      tx_valid <= txv_d;
      if (txd_en) tx_data <= tx_byte;
    end
  end
endmodule

// File: rtl/uart_fe_irq.sv
module uart_fe_irq
  import uart_fe_pkg::*;
(
  input  logic   rie,
  input  logic   tie,
  input  flags_t flags,
  output logic   irq_rx,
  output logic   irq_tx
);
  // R3 R4: levels follow the stored enables and flags directly
  always_comb begin
    irq_rx = rie && flags.dr;
    irq_tx = tie && (flags.te || flags.tend);
  end
endmodule

// File: rtl/uart_reg_front.sv
module uart_reg_front
  import uart_fe_pkg::*;
#(
  parameter int DATA_W         = 16,
  parameter int BYTE_W         = 8,
  parameter int RATE_W         = 8,
  parameter int TX_DELAY_TICKS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic              tick,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              tx_ready,
  output logic              irq_rx,
  output logic              irq_tx
);
  logic              rst_n_sync;
  reg_addr_e         addr;
  logic              wr_en, rd_en;
  logic [DATA_W-1:0] mode_q, ctrl_q, fctl_q;
  logic [RATE_W-1:0] rate_q;
  flags_t            flags_q;
  logic [DATA_W-1:0] rdata_d;

  uart_fe_rstsync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  always_comb begin
    addr  = reg_addr_e'(bus_addr);
    wr_en = bus_sel && bus_wr;
    rd_en = bus_sel && !bus_wr;
  end

  uart_fe_cfg #(.DATA_W(DATA_W), .RATE_W(RATE_W)) u_cfg (
    .clk(clk), .rst_n(rst_n_sync), .wr_en(wr_en), .wr_addr(addr),
    .wr_data(bus_wdata), .mode_q(mode_q), .rate_q(rate_q),
    .ctrl_q(ctrl_q), .fctl_q(fctl_q)
  );

  uart_fe_flags #(.BYTE_W(BYTE_W), .TX_DELAY_TICKS(TX_DELAY_TICKS)) u_flags (
    .clk(clk), .rst_n(rst_n_sync), .tick(tick), .rx_valid(rx_valid),
    .rd_rx(rx_ready),
    .st_wr(wr_en && addr == REG_STAT), .st_clr(bus_wdata[FLAG_W-1:0]),
    .tx_wr(wr_en && addr == REG_TXD), .tx_byte(bus_wdata[BYTE_W-1:0]),
    .tx_ready(tx_ready), .flags_q(flags_q),
    .tx_valid(tx_valid), .tx_data(tx_data)
  );

  uart_fe_irq u_irq (
    .rie(ctrl_q[CTRL_RIE]), .tie(ctrl_q[CTRL_TIE]), .flags(flags_q),
    .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  // R8: pop the receiver on a data read
  assign rx_ready = rd_en && (addr == REG_RXD);

  // R11: read mux, registered one cycle
  always_comb begin
    unique case (addr)
      REG_MODE:  rdata_d = mode_q;
      REG_RATE:  rdata_d = DATA_W'(rate_q);
      REG_CTRL:  rdata_d = ctrl_q;
      REG_TXD:   rdata_d = '0;
      REG_STAT:  rdata_d = DATA_W'(flags_q);
      REG_RXD:   rdata_d = rx_valid ? DATA_W'(rx_data) : '0;
      REG_FCTL:  rdata_d = fctl_q;
      REG_RXCNT: rdata_d = DATA_W'(rx_valid);
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_en;
      if (rd_en) bus_rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/uart_reg_front_chk.sv
module uart_reg_front_chk #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [2:0]        bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_rvalid,
  input logic              tick,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic [BYTE_W-1:0] tx_data,
  input logic              tx_ready,
  input logic              irq_rx,
  input logic              irq_tx
);
  AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr) |=> bus_rvalid);                               // R11
  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |=> !bus_rvalid);                             // R11
  AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !(bus_sel && bus_wr && bus_addr == 3'd3))
      |=> (tx_valid && $stable(tx_data)));                              // R6
  AST_RX_POP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |=> !irq_rx);                                              // R8
  AST_RIE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 3'd2 && !bus_wdata[0]) |=> !irq_rx); // R12
  AST_TIE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 3'd2 && !bus_wdata[1]) |=> !irq_tx); // R12
  AST_DR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 3'd4 && bus_wdata[0] && !(tick && rx_valid))
      |=> !irq_rx);                                                     // R5
endmodule

bind uart_reg_front uart_reg_front_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) chk_i (
  .clk(clk), .rst_n(rst_n_sync), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
  .tick(tick), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
  .irq_rx(irq_rx), .irq_tx(irq_tx)
);

// File: tb/uart_reg_front_tb_top.sv
`timescale 1ns/1ps
module uart_reg_front_tb_top;
  localparam int D = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr, tick, rx_valid, tx_ready;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [7:0]  rx_data;
  logic [15:0] bus_rdata;
  logic        bus_rvalid, rx_ready, tx_valid, irq_rx, irq_tx;
  logic [7:0]  tx_data;

  int errors = 0;
  int checks = 0;

  // model state
  logic [15:0] m_mode, m_ctrl, m_fctl, m_rdata;
  logic [7:0]  m_rate, m_txd;
  logic        m_dr, m_te, m_tend, m_txv, m_rvalid;
  logic [2:0]  m_raddr;
  int          m_cnt;

  always #10 clk = ~clk;

  uart_reg_front #(.DATA_W(16), .BYTE_W(8), .RATE_W(8), .TX_DELAY_TICKS(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .tick(tick), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_ready(rx_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string rd_tag(input logic [2:0] a);
    case (a)
      3'd2: return "R12";
      3'd3: return "R11";
      3'd4: return "R5";
      3'd5: return "R8";
      3'd7: return "R10";
      default: return "R2";
    endcase
  endfunction

  function automatic logic [15:0] exp_read(input logic [2:0] a, input logic rv, input logic [7:0] rd);
    case (a)
      3'd0: return m_mode;
      3'd1: return {8'h00, m_rate};
      3'd2: return m_ctrl;
      3'd4: return {13'd0, m_tend, m_te, m_dr};
      3'd5: return rv ? {8'h00, rd} : 16'h0000;
      3'd6: return m_fctl;
      3'd7: return {15'd0, rv};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic model_reset();
    m_mode = '0; m_ctrl = '0; m_fctl = '0; m_rate = '0; m_rdata = '0;
    m_dr = 0; m_te = 0; m_tend = 0; m_txv = 0; m_txd = '0;
    m_rvalid = 0; m_raddr = '0; m_cnt = 0;
  endtask

  task automatic compare_all();
    chk("R11 rvalid", bus_rvalid, m_rvalid);
    if (m_rvalid) chk(rd_tag(m_raddr), bus_rdata, m_rdata);
    chk("R3 irq_rx", irq_rx, m_ctrl[0] & m_dr);
    chk("R4 irq_tx", irq_tx, m_ctrl[1] & (m_te | m_tend));
    chk("R6 tx_valid", tx_valid, m_txv);
    if (m_txv) chk("R6 tx_data", tx_data, m_txd);
  endtask

  task automatic step(input logic sel, input logic wr, input logic [2:0] a,
                      input logic [15:0] wd, input logic tk, input logic rv,
                      input logic [7:0] rd, input logic tr);
    logic rde, wre, fire, dr_n, te_n, tend_n, txv_n;
    int cnt_n;
    bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    tick = tk; rx_valid = rv; rx_data = rd; tx_ready = tr;
    #1;
    rde = sel & ~wr; wre = sel & wr;
    chk("R8 rx_ready", rx_ready, rde && a == 3'd5);
    fire = tk && (m_cnt == 1);
    cnt_n = (wre && a == 3'd3) ? D : ((tk && m_cnt != 0) ? m_cnt - 1 : m_cnt);
    if (rde && a == 3'd5) dr_n = 0;
    else if (tk && rv) dr_n = 1;
    else dr_n = m_dr & ~(wre && a == 3'd4 && wd[0]);
    te_n   = fire | (m_te   & ~(wre && a == 3'd4 && wd[1]));
    tend_n = fire | (m_tend & ~(wre && a == 3'd4 && wd[2]));
    txv_n  = (wre && a == 3'd3) ? 1'b1 : ((m_txv && tr) ? 1'b0 : m_txv);
    if (rde) begin m_rdata = exp_read(a, rv, rd); m_raddr = a; end
    m_rvalid = rde;
    if (wre && a == 3'd3) m_txd = wd[7:0];
    if (wre && a == 3'd0) m_mode = wd;
    if (wre && a == 3'd1) m_rate = wd[7:0];
    if (wre && a == 3'd2) m_ctrl = wd;
    if (wre && a == 3'd6) m_fctl = wd;
    m_dr = dr_n; m_te = te_n; m_tend = tend_n; m_txv = txv_n; m_cnt = cnt_n;
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    step(1, 1, a, d, 0, 0, 8'h00, 0);
  endtask
  task automatic rd_reg(input logic [2:0] a, input logic rv, input logic [7:0] rd);
    step(1, 0, a, 16'h0, 0, rv, rd, 0);
  endtask
  task automatic tick_once(input logic rv);
    step(0, 0, 3'd0, 16'h0, 1, rv, 8'h00, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    tick = 0; rx_valid = 0; rx_data = '0; tx_ready = 0;
    rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 irq_rx in reset", irq_rx, 0);
    chk("R1 irq_tx in reset", irq_tx, 0);
    chk("R1 tx_valid in reset", tx_valid, 0);
    chk("R1 rvalid in reset", bus_rvalid, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: every stored register and status reads zero after reset
    for (int a = 0; a < 7; a++) begin
      rd_reg(3'(a), 0, 8'h00);
      chk("R1 read after reset", bus_rdata, 0);
    end

    // R2: storage widths
    wr_reg(3'd0, 16'hBEEF); rd_reg(3'd0, 0, 0); chk("R2 mode", bus_rdata, 16'hBEEF);
    wr_reg(3'd1, 16'h01A5); rd_reg(3'd1, 0, 0); chk("R2 rate upper bits", bus_rdata, 16'h00A5);
    wr_reg(3'd6, 16'h1234); rd_reg(3'd6, 0, 0); chk("R2 fifo ctl", bus_rdata, 16'h1234);

    // R9 R3 R12
    wr_reg(3'd2, 16'h0003);
    rd_reg(3'd2, 0, 0); chk("R12 ctrl readback", bus_rdata, 16'h0003);
    tick_once(1);
    chk("R3 irq_rx on data ready", irq_rx, 1);
    rd_reg(3'd4, 0, 0); chk("R9 data ready after tick", bus_rdata, 16'h0001);
    wr_reg(3'd2, 16'h0002);
    chk("R12 irq_rx dropped", irq_rx, 0);

    // R6 R7 with a two-tick countdown
    step(1, 1, 3'd3, 16'h7741, 1, 0, 0, 0);   // same-cycle tick does not count
    chk("R6 tx_data offered", tx_data, 8'h41);
    tick_once(0);
    rd_reg(3'd4, 0, 0); chk("R7 no flags after first tick", bus_rdata, 16'h0001);
    tick_once(0);
    rd_reg(3'd4, 0, 0); chk("R7 flags after last tick", bus_rdata, 16'h0007);
    chk("R4 irq_tx raised", irq_tx, 1);
    step(0, 0, 3'd0, 0, 0, 0, 0, 1);
    chk("R6 accepted", tx_valid, 0);

    // R5: clear ones only
    wr_reg(3'd4, 16'h0002);
    rd_reg(3'd4, 0, 0); chk("R5 clear te only", bus_rdata, 16'h0005);
    wr_reg(3'd4, 16'h0004);
    chk("R5 irq_tx low", irq_tx, 0);

    // R8 R10
    rd_reg(3'd7, 1, 8'h5A); chk("R10 count one", bus_rdata, 16'h0001);
    rd_reg(3'd7, 0, 8'h5A); chk("R10 count zero", bus_rdata, 16'h0000);
    rd_reg(3'd5, 1, 8'h5A); chk("R8 byte returned", bus_rdata, 16'h005A);
    rd_reg(3'd4, 0, 0);     chk("R8 data ready cleared", bus_rdata, 16'h0000);
    rd_reg(3'd5, 0, 8'h33); chk("R8 zero when empty", bus_rdata, 16'h0000);
    step(1, 0, 3'd5, 0, 1, 1, 8'h66, 0);      // read beats tick
    rd_reg(3'd4, 0, 0);     chk("R8 read clear wins", bus_rdata, 16'h0000);

    // R11: read-only writes ignored, tx data reads zero
    wr_reg(3'd5, 16'hFFFF); wr_reg(3'd7, 16'hFFFF);
    rd_reg(3'd4, 0, 0); chk("R11 status untouched", bus_rdata, 16'h0000);
    rd_reg(3'd0, 0, 0); chk("R11 mode untouched", bus_rdata, 16'hBEEF);
    rd_reg(3'd3, 0, 0); chk("R11 tx data reads zero", bus_rdata, 16'h0000);

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 3) != 0, $urandom % 2, 3'($urandom % 8),
           16'($urandom), ($urandom % 4) == 0, $urandom % 2,
           8'($urandom), $urandom % 2);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule